// File: doc/BRIEF.md
# Delayed-Update LMS Neuron Trainer

A single linear neuron trained online by gradient descent. Every clock it can take one input vector and one target value. Its output is the weighted sum of the inputs plus a bias. The error is the target minus that output. Both are computed from the weights currently held, even when earlier samples have not yet been folded into those weights.

Gradient terms (error times input, and the error alone for the bias) are summed over a window of NR+1 accepted samples. During the window the coefficients stay frozen. On the last sample of the window each coefficient moves by the summed gradient, scaled down by a programmable right shift. The shift acts as the step size, so it can be made smaller to offset the staleness that the delayed update causes. All arithmetic is signed fixed point, and the coefficients saturate.

Top module: `lms_delayed_trainer`

## Requirements
- R1: One cycle after a sample is accepted, out_valid_o is 1 and y_o holds the bias plus the sum of the products of each input with its weight. The weights and bias used are the values held on the accepting edge, before any update made on that edge.
- R2: In the same cycle as R1, err_o holds the target d_i minus y_o, as a signed value.
- R3: Weights and bias change only on the edge that accepts the last sample of a window. On every other edge they keep their value.
- R4: A window is nr+1 accepted samples. The value of nr is taken from nr_i on the first sample of the window. Later changes to nr_i within the window do not alter its length.
- R5: At the end of a window, each weight becomes w + floor(S / 2^s). S is the sum over the window of error times that weight's input, and s is mu_shift_i on the closing sample. The bias uses the sum of the errors in the same way.
- R6: An updated coefficient is clamped to the range -2^(WW-1) to 2^(WW-1)-1.
- R7: Gradient sums restart from zero after every window end, so a new window's update depends only on its own samples.
- R8: in_ready_o is always 1. A cycle with in_valid_i low leaves out_valid_o at 0 one cycle later and changes no weight, bias or window position.
- R9: An active-low reset clears all weights, the bias, the gradient sums, the window position and out_valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample present |
| in_ready_o | output | 1 | Sample can be taken (always 1) |
| x_i | input | N_IN*DW | Input vector, element k in bits [k*DW +: DW] |
| d_i | input | DW | Target value |
| nr_i | input | NR_W | Window length minus one, taken at window start |
| mu_shift_i | input | SHW | Step size as right-shift amount |
| y_o | output | YW | Neuron output of last accepted sample |
| err_o | output | YW+1 | Error of last accepted sample |
| out_valid_o | output | 1 | y_o and err_o refer to the previous cycle's sample |
| w_o | output | N_IN*WW | Weights, weight k in bits [k*WW +: WW] |
| b_o | output | WW | Bias |

## Verification
The bench builds the neuron with four 12-bit inputs, 16-bit coefficients, a 4-bit window register and a 5-bit shift. Window lengths therefore range from 1 to 16 samples, and the bench mixes lengths of 1, 2, 3 and 4. A change of nr_i in the middle of a window can be observed. A single full-scale sample at shift 0 drives the weights into the positive clamp, and the next sample drives them into the negative clamp. The bench also tests idle cycles between samples and a reset in the middle of a window.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int unsigned LMS_N_IN = 4;
  localparam int unsigned LMS_DW   = 12;
  localparam int unsigned LMS_WW   = 16;
  localparam int unsigned LMS_NR_W = 4;
  localparam int unsigned LMS_SHW  = 5;
endpackage

// File: rtl/lms_dot.sv
module lms_dot #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned DW   = 12,
  parameter int unsigned WW   = 16,
  parameter int unsigned YW   = 32
) (
  input  logic [N_IN*DW-1:0] x_i,
  input  logic [N_IN*WW-1:0] w_i,
  input  logic [WW-1:0]      b_i,
  output logic [YW-1:0]      y_o
);
  localparam int unsigned PW = DW + WW;

  logic signed [PW-1:0] prod [N_IN];

  for (genvar k = 0; k < N_IN; k++) begin : g_mul
    assign prod[k] = $signed(x_i[k*DW +: DW]) * $signed(w_i[k*WW +: WW]);
  end

  always_comb begin
    logic signed [YW-1:0] sum;
    sum = $signed({{(YW-WW){b_i[WW-1]}}, b_i});
    for (int k = 0; k < N_IN; k++) begin
      sum = sum + $signed({{(YW-PW){prod[k][PW-1]}}, prod[k]});
    end
    y_o = sum;
  end
endmodule

// File: rtl/lms_lane.sv
module lms_lane #(
  parameter int unsigned DW  = 12,
  parameter int unsigned WW  = 16,
  parameter int unsigned EW  = 33,
  parameter int unsigned AW  = 49,
  parameter int unsigned SHW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  x_i,
  input  logic [EW-1:0]  err_i,
  input  logic           upd_en_i,
  input  logic           close_i,
  input  logic [SHW-1:0] shift_i,
  output logic [WW-1:0]  w_o
);
  localparam int unsigned GW = EW + DW;
  localparam logic signed [AW:0] WMAX = $signed({{(AW-WW+2){1'b0}}, {(WW-1){1'b1}}});
  localparam logic signed [AW:0] WMIN = $signed({{(AW-WW+2){1'b1}}, {(WW-1){1'b0}}});

  logic signed [GW-1:0] prod;
  logic signed [AW-1:0] acc_q, total, step;
  logic signed [AW:0]   w_sum;
  logic signed [WW-1:0] w_q, w_sat;

  assign prod  = $signed(err_i) * $signed(x_i);
  assign total = acc_q + $signed({{(AW-GW){prod[GW-1]}}, prod});
  assign step  = total >>> shift_i;  // floor division by 2^shift
  assign w_sum = $signed({{(AW+1-WW){w_q[WW-1]}}, w_q}) + $signed({step[AW-1], step});

  always_comb begin
    if (w_sum > WMAX)      w_sat = WMAX[WW-1:0];
    else if (w_sum < WMIN) w_sat = WMIN[WW-1:0];
    else                   w_sat = w_sum[WW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      w_q   <= '0;
    end else if (upd_en_i) begin
      if (close_i) begin
        acc_q <= '0;
        w_q   <= w_sat;
      end else begin
        acc_q <= total;
      end
    end
  end

  assign w_o = w_q;

  p_w_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_en_i && close_i) |=> $stable(w_q));

  p_acc_fresh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && close_i) |=> (acc_q == '0));
endmodule

// File: rtl/lms_delayed_trainer.sv
module lms_delayed_trainer
  import lms_pkg::*;
#(
  parameter int unsigned N_IN = LMS_N_IN,
  parameter int unsigned DW   = LMS_DW,
  parameter int unsigned WW   = LMS_WW,
  parameter int unsigned NR_W = LMS_NR_W,
  parameter int unsigned SHW  = LMS_SHW,
  localparam int unsigned YW  = DW + WW + $clog2(N_IN + 1) + 1,
  localparam int unsigned EW  = YW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [N_IN*DW-1:0] x_i,
  input  logic [DW-1:0]     d_i,
  input  logic [NR_W-1:0]   nr_i,
  input  logic [SHW-1:0]    mu_shift_i,
  output logic [YW-1:0]     y_o,
  output logic [EW-1:0]     err_o,
  output logic              out_valid_o,
  output logic [N_IN*WW-1:0] w_o,
  output logic [WW-1:0]     b_o
);
  localparam int unsigned AW = EW + DW + NR_W;

  logic            accept, first, last;
  logic [NR_W-1:0] cnt_q, nr_q, nr_live;
  logic [YW-1:0]   y, y_q;
  logic [EW-1:0]   err, err_q;
  logic            ov_q;

  assign in_ready_o = 1'b1;
  assign accept     = in_valid_i;
  assign first      = (cnt_q == '0);
  assign nr_live    = first ? nr_i : nr_q;  // length frozen after first sample
  assign last       = (cnt_q == nr_live);

  lms_dot #(.N_IN(N_IN), .DW(DW), .WW(WW), .YW(YW)) u_dot (
    .x_i(x_i), .w_i(w_o), .b_i(b_o), .y_o(y)
  );

  assign err = {{(EW-DW){d_i[DW-1]}}, d_i} - {y[YW-1], y};

  for (genvar k = 0; k < N_IN; k++) begin : g_lane
    lms_lane #(.DW(DW), .WW(WW), .EW(EW), .AW(AW), .SHW(SHW)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i[k*DW +: DW]), .err_i(err),
      .upd_en_i(accept), .close_i(last), .shift_i(mu_shift_i),
      .w_o(w_o[k*WW +: WW])
    );
  end

  lms_lane #(.DW(DW), .WW(WW), .EW(EW), .AW(AW), .SHW(SHW)) u_bias (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(DW'(1)), .err_i(err),
    .upd_en_i(accept), .close_i(last), .shift_i(mu_shift_i), .w_o(b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      nr_q  <= '0;
      ov_q  <= 1'b0;
      y_q   <= '0;
      err_q <= '0;
    end else begin
      ov_q <= accept;
      if (accept) begin
        nr_q  <= nr_live;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        y_q   <= y;
        err_q <= err;
      end
    end
  end

  assign y_o         = y_q;
  assign err_o       = err_q;
  assign out_valid_o = ov_q;

  p_out_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> (!out_valid_o && $stable(cnt_q) && $stable(b_o)));

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q <= nr_q));

  p_len_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !first) |=> $stable(nr_q));
endmodule

// File: tb/tb_lms_delayed_trainer.sv
module tb_lms_delayed_trainer;
  localparam int N = 4, DW = 12, WW = 16, NR_W = 4, SHW = 5;
  localparam int YW = DW + WW + $clog2(N + 1) + 1;
  localparam int EW = YW + 1;

  logic clk = 0, rst_ni = 0, in_valid = 0, in_ready, out_valid;
  logic [N*DW-1:0] x;
  logic [DW-1:0] d;
  logic [NR_W-1:0] nr;
  logic [SHW-1:0] sh;
  logic [YW-1:0] y;
  logic [EW-1:0] err;
  logic [N*WW-1:0] w;
  logic [WW-1:0] b;

  always #5 clk = ~clk;

  lms_delayed_trainer dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .x_i(x), .d_i(d), .nr_i(nr), .mu_shift_i(sh), .y_o(y), .err_o(err),
    .out_valid_o(out_valid), .w_o(w), .b_o(b)
  );

  int n_chk = 0, n_fail = 0;
  longint mw[N], macc[N], mb, maccb;
  int mcnt, mnr;

  // x0 x1 x2 x3 d nr shift
  localparam int VEC [12][7] = '{
    '{  100,  -50,   25,   10,   300, 2,  6},
    '{  -20,   40,   60,  -80,  -150, 2,  6},
    '{    5,    5,    5,    5,    40, 2,  6},
    '{  300, -200,  100,    0,   500, 0,  3},
    '{-1000,  700,    0,   50,  -900, 0, 10},
    '{   12,  -34,   56,  -78,    90, 1,  5},
    '{  200,  200, -200, -200,     0, 7,  5},
    '{-2048, 2047,-2048, 2047,  2047, 3,  0},
    '{    1,    2,    3,    4,    -5, 9, 12},
    '{   -7,   -7,    7,    7,    13, 0, 12},
    '{   50,    0,  -50,    0, -2048,15,  4},
    '{  640, -320,  160,  -80,  1000, 0,  1}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin mw[k] = 0; macc[k] = 0; end
    mb = 0; maccb = 0; mcnt = 0; mnr = 0;
  endtask

  task automatic check_weights(input string req);
    bit ok = 1;
    for (int k = 0; k < N; k++)
      if (longint'($signed(w[k*WW +: WW])) != mw[k]) ok = 0;
    if (longint'($signed(b)) != mb) ok = 0;
    check(ok, req, longint'($signed(w[0 +: WW])), mw[0]);
  endtask

  task automatic send(input int v[7], input string tag);
    longint xs[N], ey, ee;
    for (int k = 0; k < N; k++) begin
      xs[k] = v[k];
      x[k*DW +: DW] = DW'(v[k]);
    end
    d = DW'(v[4]); nr = NR_W'(v[5]); sh = SHW'(v[6]); in_valid = 1;
    ey = mb;
    for (int k = 0; k < N; k++) ey += mw[k] * xs[k];
    ee = longint'(v[4]) - ey;
    if (mcnt == 0) mnr = v[5];
    for (int k = 0; k < N; k++) macc[k] += ee * xs[k];
    maccb += ee;
    if (mcnt == mnr) begin
      for (int k = 0; k < N; k++) begin
        mw[k] = sat(mw[k] + (macc[k] >>> v[6])); macc[k] = 0;
      end
      mb = sat(mb + (maccb >>> v[6])); maccb = 0; mcnt = 0;
    end else mcnt++;
    @(negedge clk);
    check(out_valid == 1'b1, {tag, " R1 valid"}, longint'(out_valid), 1);
    check(longint'($signed(y)) == ey, {tag, " R1 y"}, longint'($signed(y)), ey);
    check(longint'($signed(err)) == ee, {tag, " R2 err"}, longint'($signed(err)), ee);
    check_weights({tag, " R3 R4 R5 R7 weights"});
    in_valid = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; in_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    model_reset();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    x = '0; d = '0; nr = '0; sh = '0;
    do_reset();
    check(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
    check_weights("R9 weights after reset");
    check(in_ready == 1'b1, "R8 ready", longint'(in_ready), 1);

    // table walk: back-to-back except for idle gaps after samples 3 and 7
    for (int i = 0; i < 12; i++) begin
      send(VEC[i], $sformatf("vec%0d", i));
      if (i == 2 || i == 6) begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 idle no valid", longint'(out_valid), 0);
        check_weights("R8 idle no change");
      end
    end

    // R8: idle in mid-window keeps window position
    send('{10, 20, 30, 40, 100, 1, 3}, "mididle1");
    repeat (4) @(negedge clk);
    check_weights("R8 R3 idle mid-window");
    send('{-10, 5, 0, 8, -60, 0, 3}, "mididle2");

    // R6: saturation both ways
    do_reset();
    send('{2047, 2047, 2047, 2047, 2047, 0, 0}, "sat_hi");
    check(longint'($signed(w[0 +: WW])) == 32767, "R6 clamp high", longint'($signed(w[0 +: WW])), 32767);
    send('{2047, 2047, 2047, 2047, 2047, 0, 0}, "sat_lo");
    check(longint'($signed(w[0 +: WW])) == -32768, "R6 clamp low", longint'($signed(w[0 +: WW])), -32768);

    // R9 R7: reset in mid-window discards partial sums
    send('{100, 100, 100, 100, 50, 3, 2}, "pre_rst");
    do_reset();
    check_weights("R9 mid-window reset");
    send('{30, -30, 60, -60, 400, 0, 4}, "post_rst");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule